// File: doc/BRIEF.md
# Prescaled Match Timer

A free-running counter whose advance rate is divided down by a programmable prescaler, watched by four compare channels. Each compare channel can raise a sticky flag, send the counter back to zero, or halt it. It also drives one external output bit through a programmable action. The counting events come either from the block clock or from edges of one of several external count inputs. Those inputs are synchronized inside the block.

Software sets the block up through a flat word-addressed register port: a valid/write strobe, a 4-bit word address, 32-bit write data and a combinational read path. Each channel also has a shadow compare value. The shadow can be reloaded into the live compare value whenever the counter restarts, so the next period picks up a new setting without a race. In pulse-width mode, one channel sets the period and every other enabled channel produces a pulse whose width depends on its compare value.

Top module: `tmr_match_timer`

## Requirements
- R1: After reset, every readable register reads 0, `match_out` is 0 and `irq` is 0. The word addresses are: control 0, prescale 1, counter 2 (read-only), match control 3, output control 4, flags 5, output state 6, compare value of channel i at 8+i, shadow of channel i at 12+i.
- R2: Control bits [3:2] pick the counting event: 0 = every clock, 1 = rising edge, 2 = falling edge, 3 = both edges of the count input chosen by control bits [5:4]. Each input is synchronized through two flops, and each input edge counts exactly once.
- R3: The prescaler counts events up to the prescale value P (address 1) and then wraps. The counter advances once every P+1 events, and only while the run bit (control bit 0) is 1.
- R4: While the clear bit (control bit 1) is 1, the counter and the prescaler are forced to 0 on every clock, whether the timer is running or not.
- R5: The match control word (address 3) holds 3 bits for each channel i: bit 3i = flag enable, bit 3i+1 = reset on match, bit 3i+2 = stop on match. A match happens on a counting tick on which the counter equals the compare value. With reset enabled, that tick loads 0 into the counter, so the counter cycles from 0 to M.
- R6: Stop on match clears the run bit, and the counter holds the compare value.
- R7: A match on a channel whose flag enable is set sets flag bit i (address 5), and `irq` is the OR of the flags. Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If a set and a clear reach the same bit in the same cycle, the set wins.
- R8: Output control bits [2i+1:2i] give the action of channel i on a match: 0 = leave unchanged, 1 = drive low, 2 = drive high, 3 = toggle. A write to address 6 loads the output bits directly; this is how initial values are set.
- R9: Output control bits [11:8] enable pulse-width mode per channel, and bits [13:12] name the period channel. A period channel with its pulse-width bit set resets the counter on its match. Every other pulse-width channel goes high on its own match and low on the restart. If both happen on the same tick, low wins.
- R10: Match control bit 12+i enables reload for channel i. On each match-driven counter restart, the shadow value (address 12+i) is copied into the compare value (address 8+i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write access |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cnt_in | input | 4 | External count inputs, asynchronous |
| match_out | output | 4 | External match output bits |
| irq | output | 1 | OR of the match flags |

## Verification
The bench draws random prescale values, compare values and run lengths, and predicts the counter from the period arithmetic. An off-by-one in either the prescaler wrap or the reset-on-match tick would shift every prediction. Directed cases cover the following:
- A stop on match, where a design that increments on the stopping tick ends one count too high.
- A toggle action, which would come out with the wrong parity after several periods.
- A pulse-width channel sampled on every cycle of several periods, which exposes a high edge or low edge one tick late.
- A shadow reload, where a design that skips the copy keeps the old period.
- External-input counting in all three edge modes, with pulses on a channel that is not selected, which catches double counting or a wrong input select.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
   localparam logic [ADDR_W-1:0] A_PRESC = 4'd1;
   localparam logic [ADDR_W-1:0] A_COUNT = 4'd2;
   localparam logic [ADDR_W-1:0] A_MCTL  = 4'd3;
   localparam logic [ADDR_W-1:0] A_OCTL  = 4'd4;
   localparam logic [ADDR_W-1:0] A_FLAGS = 4'd5;
   localparam logic [ADDR_W-1:0] A_OUTS  = 4'd6;
   localparam int A_MATCH_BASE  = 8;
   localparam int A_SHADOW_BASE = 12;

   // action on a compare hit
   typedef enum logic [1:0] {
      ACT_KEEP = 2'd0,
      ACT_LOW  = 2'd1,
      ACT_HIGH = 2'd2,
      ACT_FLIP = 2'd3
   } act_e;

   // source of counting events
   typedef enum logic [1:0] {
      CM_CLOCK = 2'd0,
      CM_RISE  = 2'd1,
      CM_FALL  = 2'd2,
      CM_BOTH  = 2'd3
   } cmode_e;

endpackage

// File: rtl/tmr_cnt_sync.sv
module tmr_cnt_sync
   import tmr_pkg::*;
#(
   parameter int NCIN  = 4,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCIN-1:0]  cnt_in,
   input  logic [SEL_W-1:0] sel,
   input  cmode_e           mode,
   output logic             evt
);

   logic [NCIN-1:0] s1_q, s2_q;
   logic            picked, prev_q;
   logic            rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q   <= '0;
         s2_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         s1_q   <= cnt_in;
         s2_q   <= s1_q;
         prev_q <= picked;
      end
   end

   generate
      if (NCIN == 1) begin : g_one
         assign picked = s2_q[0];
      end else begin : g_many
         assign picked = s2_q[sel];
      end
   endgenerate

   assign rise = picked & ~prev_q;
   assign fall = ~picked & prev_q;

   always_comb begin
      unique case (mode)
         CM_CLOCK: evt = 1'b1;
         CM_RISE:  evt = rise;
         CM_FALL:  evt = fall;
         CM_BOTH:  evt = rise | fall;
         default:  evt = 1'b0;
      endcase
   end

   // R2: an input edge yields one event, so two events in a row in a
   // single-edge mode are impossible
   a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && (mode == CM_RISE || mode == CM_FALL)) |=> !evt)
      else $error("a_r2_single_event");

endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] tc,
   input  logic             restart,
   input  logic             rld_en,
   input  act_e             act,
   input  logic             pwm_on,
   input  logic             is_period,
   input  logic             wr_match,
   input  logic             wr_shadow,
   input  logic [CNT_W-1:0] wval,
   input  logic             out_we,
   input  logic             out_wval,
   output logic [CNT_W-1:0] match_q,
   output logic [CNT_W-1:0] shadow_q,
   output logic             hit,
   output logic             out_q
);

   logic pwm_eff;

   assign hit     = tick && (tc == match_q);
   assign pwm_eff = pwm_on && !is_period;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q  <= '0;
         shadow_q <= '0;
      end else begin
         if (restart && rld_en) match_q <= shadow_q;
         if (wr_match)          match_q <= wval;
         if (wr_shadow)         shadow_q <= wval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else begin
         if (out_we) out_q <= out_wval;
         if (pwm_eff) begin
            if (restart)  out_q <= 1'b0;
            else if (hit) out_q <= 1'b1;
         end else if (hit) begin
            unique case (act)
               ACT_LOW:  out_q <= 1'b0;
               ACT_HIGH: out_q <= 1'b1;
               ACT_FLIP: out_q <= ~out_q;
               default:  out_q <= out_q;
            endcase
         end
      end
   end

   a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !pwm_eff && act == ACT_FLIP) |=> (out_q != $past(out_q)))
      else $error("a_r8_toggle");

   a_r9_pwm_low_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && pwm_eff) |=> !out_q)
      else $error("a_r9_pwm_low_on_restart");

   a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && rld_en && !wr_match) |=> (match_q == $past(shadow_q)))
      else $error("a_r10_reload");

endmodule

// File: rtl/tmr_match_timer.sv
module tmr_match_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int NCH    = 4,
   parameter int NCIN   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [3:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NCIN-1:0]   cnt_in,
   output logic [NCH-1:0]    match_out,
   output logic              irq
);

   localparam int SEL_W   = (NCIN > 1) ? $clog2(NCIN) : 1;
   localparam int PSEL_W  = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int MCTL_W  = 3 * NCH + NCH;
   localparam int RLD_LSB = 3 * NCH;
   localparam int PWM_LSB = 2 * NCH;
   localparam int PER_LSB = 3 * NCH;

   initial begin
      assert (NCH >= 1 && NCH <= 4) else $error("NCH must be 1..4");
      assert (NCIN >= 1 && NCIN <= 4) else $error("NCIN must be 1..4");
      assert (CNT_W >= 2 && CNT_W <= DATA_W) else $error("CNT_W out of range");
      assert (MCTL_W <= DATA_W && PER_LSB + PSEL_W <= DATA_W) else $error("DATA_W too small");
   end

   // register state
   logic              run_q, clr_q;
   cmode_e            mode_q;
   logic [SEL_W-1:0]  sel_q;
   logic [CNT_W-1:0]  presc_q, pc_q, tc_q;
   logic [3*NCH-1:0]  mctl_q;
   logic [NCH-1:0]    rld_q, pwm_q, flag_q;
   logic [2*NCH-1:0]  act_q;
   logic [PSEL_W-1:0] per_q;

   // decode
   logic wr, wr_ctrl, wr_presc, wr_mctl, wr_octl, wr_flags, wr_outs;
   logic [NCH-1:0] wr_match, wr_shadow;
   logic [NCH-1:0] irq_en, rst_en, stop_en, hits, is_period;
   logic [CNT_W-1:0] match_v [NCH];
   logic [CNT_W-1:0] shadow_v [NCH];
   logic evt, tick, rst_hit, stop_hit;

   assign wr       = bus_valid && bus_write;
   assign wr_ctrl  = wr && (bus_addr == A_CTRL);
   assign wr_presc = wr && (bus_addr == A_PRESC);
   assign wr_mctl  = wr && (bus_addr == A_MCTL);
   assign wr_octl  = wr && (bus_addr == A_OCTL);
   assign wr_flags = wr && (bus_addr == A_FLAGS);
   assign wr_outs  = wr && (bus_addr == A_OUTS);

   tmr_cnt_sync #(.NCIN(NCIN), .SEL_W(SEL_W)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_in (cnt_in),
      .sel    (sel_q),
      .mode   (mode_q),
      .evt    (evt)
   );

   assign tick = run_q && !clr_q && evt && (pc_q >= presc_q);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         assign irq_en[i]    = mctl_q[3*i];
         assign rst_en[i]    = mctl_q[3*i+1];
         assign stop_en[i]   = mctl_q[3*i+2];
         assign wr_match[i]  = wr && (bus_addr == ADDR_W'(A_MATCH_BASE + i));
         assign wr_shadow[i] = wr && (bus_addr == ADDR_W'(A_SHADOW_BASE + i));
         assign is_period[i] = (per_q == PSEL_W'(i));

         tmr_match_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .tc        (tc_q),
            .restart   (rst_hit),
            .rld_en    (rld_q[i]),
            .act       (act_e'(act_q[2*i +: 2])),
            .pwm_on    (pwm_q[i]),
            .is_period (is_period[i]),
            .wr_match  (wr_match[i]),
            .wr_shadow (wr_shadow[i]),
            .wval      (bus_wdata[CNT_W-1:0]),
            .out_we    (wr_outs),
            .out_wval  (bus_wdata[i]),
            .match_q   (match_v[i]),
            .shadow_q  (shadow_v[i]),
            .hit       (hits[i]),
            .out_q     (match_out[i])
         );
      end
   endgenerate

   assign rst_hit  = (|(hits & rst_en)) || (hits[per_q] && pwm_q[per_q]);
   assign stop_hit = |(hits & stop_en);
   assign irq      = |flag_q;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_q   <= 1'b0;
         mode_q  <= CM_CLOCK;
         sel_q   <= '0;
         presc_q <= '0;
         mctl_q  <= '0;
         rld_q   <= '0;
         act_q   <= '0;
         pwm_q   <= '0;
         per_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            clr_q  <= bus_wdata[1];
            mode_q <= cmode_e'(bus_wdata[3:2]);
            sel_q  <= bus_wdata[4 +: SEL_W];
         end
         if (wr_presc) presc_q <= bus_wdata[CNT_W-1:0];
         if (wr_mctl) begin
            mctl_q <= bus_wdata[3*NCH-1:0];
            rld_q  <= bus_wdata[RLD_LSB +: NCH];
         end
         if (wr_octl) begin
            act_q <= bus_wdata[2*NCH-1:0];
            pwm_q <= bus_wdata[PWM_LSB +: NCH];
            per_q <= bus_wdata[PER_LSB +: PSEL_W];
         end
      end
   end

   // counting state; a stop hit outranks a software write of the run bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pc_q   <= '0;
         tc_q   <= '0;
         flag_q <= '0;
      end else begin
         if (wr_ctrl)  run_q <= bus_wdata[0];
         if (stop_hit) run_q <= 1'b0;

         if (clr_q) begin
            pc_q <= '0;
            tc_q <= '0;
         end else begin
            if (run_q && evt) pc_q <= (pc_q >= presc_q) ? '0 : pc_q + 1'b1;
            if (tick) begin
               if (rst_hit)        tc_q <= '0;
               else if (!stop_hit) tc_q <= tc_q + 1'b1;
            end
         end

         flag_q <= (flag_q & ~(wr_flags ? bus_wdata[NCH-1:0] : '0)) | (hits & irq_en);
      end
   end

   // read path
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL: begin
            bus_rdata[0]            = run_q;
            bus_rdata[1]            = clr_q;
            bus_rdata[3:2]          = mode_q;
            bus_rdata[4 +: SEL_W]   = sel_q;
         end
         A_PRESC: bus_rdata[CNT_W-1:0] = presc_q;
         A_COUNT: bus_rdata[CNT_W-1:0] = tc_q;
         A_MCTL: begin
            bus_rdata[3*NCH-1:0]        = mctl_q;
            bus_rdata[RLD_LSB +: NCH]   = rld_q;
         end
         A_OCTL: begin
            bus_rdata[2*NCH-1:0]        = act_q;
            bus_rdata[PWM_LSB +: NCH]   = pwm_q;
            bus_rdata[PER_LSB +: PSEL_W] = per_q;
         end
         A_FLAGS: bus_rdata[NCH-1:0] = flag_q;
         A_OUTS:  bus_rdata[NCH-1:0] = match_out;
         default: begin
            for (int i = 0; i < NCH; i++) begin
               if (bus_addr == ADDR_W'(A_MATCH_BASE + i))  bus_rdata[CNT_W-1:0] = match_v[i];
               if (bus_addr == ADDR_W'(A_SHADOW_BASE + i)) bus_rdata[CNT_W-1:0] = shadow_v[i];
            end
         end
      endcase
   end

   a_r4_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |=> (tc_q == '0 && pc_q == '0))
      else $error("a_r4_clear_holds");

   a_r5_reset_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rst_hit |=> (tc_q == '0))
      else $error("a_r5_reset_to_zero");

   a_r6_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
      stop_hit |=> !run_q)
      else $error("a_r6_stop_clears_run");

   a_r7_flag_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hits & irq_en)) |=> ((flag_q & $past(hits & irq_en)) == $past(hits & irq_en)))
      else $error("a_r7_flag_set_wins");

endmodule

// File: tb/test_tmr_match_timer.sv
module test_tmr_match_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  cnt_in = '0;
   logic [3:0]  match_out;
   logic        irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_match_timer i_tmr_match_timer (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_in(cnt_in), .match_out(match_out), .irq(irq));

   function automatic int exp_count(int n, int p, int m);
      return (n / (p + 1)) % (m + 1);
   endfunction

   function automatic bit exp_pwm(int k, int m, int per);
      int c = k % (per + 1);
      return (c > m);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // hold clear, write configuration, release into run with given control
   task automatic start(int p, logic [31:0] mctl, logic [31:0] octl, logic [31:0] outs, logic [31:0] ctrl);
      wr(4'd0, 32'h2);
      wr(4'd5, 32'hF);
      wr(4'd1, p);
      wr(4'd3, mctl);
      wr(4'd4, octl);
      wr(4'd6, outs);
      wr(4'd0, ctrl);
   endtask

   task automatic pulses(int n);
      for (int k = 0; k < n; k++) begin
         cnt_in[2] = 1'b1; cnt_in[0] = 1'b1;
         wait_cyc(1);
         cnt_in[0] = 1'b0;
         wait_cyc(2);
         cnt_in[2] = 1'b0; cnt_in[0] = 1'b1;
         wait_cyc(1);
         cnt_in[0] = 1'b0;
         wait_cyc(2);
      end
      wait_cyc(6);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5EED));
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1 reset state
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), d);
         check("R1 reset reg", d, 32'h0);
      end
      check("R1 match_out", {28'h0, match_out}, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);

      // R3/R5 random prescale and period
      for (int it = 0; it < 12; it++) begin
         int p  = $urandom % 4;
         int m  = 3 + $urandom % 10;
         int ch = $urandom % 4;
         int n  = 10 + $urandom % 60;
         wr(4'(8 + ch), m);
         start(p, 32'h1 << (3 * ch + 1), 0, 0, 32'h1);
         wait_cyc(n);
         rd(4'd2, d);
         check("R3 R5 random count", d, exp_count(n, p, m));
      end

      // R6 stop on match
      wr(4'd9, 5);
      start(1, 32'h1 << 5, 0, 0, 32'h1);
      wait_cyc(30);
      rd(4'd2, d);
      check("R6 count held", d, 5);
      rd(4'd0, d);
      check("R6 run cleared", d & 32'h1, 0);

      // R7 flags and irq
      wr(4'd10, 3);
      wr(4'd8, 1);
      start(0, (32'h1 << 6) | (32'h1 << 8), 0, 0, 32'h1);
      wait_cyc(10);
      rd(4'd5, d);
      check("R7 flag set only when enabled", d, 32'h4);
      check("R7 irq high", {31'h0, irq}, 1);
      wr(4'd5, 32'h0);
      rd(4'd5, d);
      check("R7 write zero no effect", d, 32'h4);
      wr(4'd5, 32'h4);
      rd(4'd5, d);
      check("R7 write one clears", d, 32'h0);
      check("R7 irq low", {31'h0, irq}, 0);

      // R8 output actions
      wr(4'd8, 4); wr(4'd9, 2); wr(4'd10, 1); wr(4'd11, 3);
      start(0, 32'h2, 32'h4B, 32'hC, 32'h0);
      rd(4'd6, d);
      check("R8 output load", d, 32'hC);
      wr(4'd0, 32'h1);
      wait_cyc(23);
      check("R8 actions n=23", {28'h0, match_out}, {28'h0, 3'b011, 1'(((23 / 5) & 1) != 0)});
      wait_cyc(2);
      check("R8 actions n=25", {28'h0, match_out}, {28'h0, 3'b011, 1'(((25 / 5) & 1) != 0)});

      // R9 pulse-width mode
      wr(4'd11, 9); wr(4'd8, 3);
      start(0, 32'h0, 32'h3900, 32'h0, 32'h1);
      for (int k = 1; k <= 25; k++) begin
         wait_cyc(1);
         check("R9 pwm output", {31'h0, match_out[0]}, {31'h0, exp_pwm(k, 3, 9)});
         rd(4'd2, d);
         check("R9 period count", d, k % 10);
      end

      // R10 shadow reload
      wr(4'd8, 4); wr(4'd12, 7);
      rd(4'd12, d);
      check("R10 shadow readback", d, 7);
      start(0, 32'h2 | (32'h1 << 12), 0, 0, 32'h1);
      wait_cyc(16);
      rd(4'd2, d);
      check("R10 count after reload", d, 3);
      rd(4'd8, d);
      check("R10 compare reloaded", d, 7);

      // R2 external count input modes, input 2 selected
      start(0, 32'h0, 0, 0, 32'h25);
      pulses(5);
      rd(4'd2, d);
      check("R2 rising edges", d, 5);
      start(0, 32'h0, 0, 0, 32'h29);
      pulses(5);
      rd(4'd2, d);
      check("R2 falling edges", d, 5);
      start(0, 32'h0, 0, 0, 32'h2D);
      pulses(5);
      rd(4'd2, d);
      check("R2 both edges", d, 10);

      // R4 clear while running
      start(0, 32'h0, 0, 0, 32'h1);
      wait_cyc(10);
      rd(4'd2, d);
      check("R4 running", d, 10);
      wr(4'd0, 32'h3);
      wait_cyc(5);
      rd(4'd2, d);
      check("R4 held at zero", d, 0);
      wr(4'd0, 32'h1);
      wait_cyc(4);
      rd(4'd2, d);
      check("R4 resumes from zero", d, 4);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule